// File: doc/BRIEF.md
# Sample-Rate Band and Clock-Ratio Detector

This block watches the frame clock of a serial audio input and decides which of three speed bands the stream belongs to: single (roughly 4 to 54 kHz), double (84 to 108 kHz) or quad (170 to 216 kHz). It measures each frame period in ticks of a fixed reference clock and reports an unsupported rate when the period falls outside all three bands. The bands do not touch, so there are gaps between them. Over the same period it counts master-clock ticks to find the master-to-frame ratio, and checks that ratio against the set of multiples allowed in the detected band. It also checks that the master frequency implied by the measurement lies between 1.024 MHz and 51.2 MHz.

The block runs on one fast system clock. The frame clock level arrives already synchronised. Master-clock and reference-clock activity arrive as one-cycle tick strobes from upstream synchronisers. A new result is taken up only when two consecutive frame periods give the same classification. If frame edges stop arriving for too long, the block reports clock loss. A de-emphasis request from the pins is passed on only while the block is in single-speed mode.

Top module: `fs_mode_detector`

## Requirements
- R1: After reset, speed_mode is 0, ratio_ok, rate_unsupported, clock_lost and deemph_en are 0.
- R2: Let N be the number of ref_tick pulses between two successive lrck_in rising edges. speed_mode becomes 1 (single) when N lies in [REF_KHZ/54, REF_KHZ/4], 2 (double) when N lies in [REF_KHZ/108, REF_KHZ/84], and 3 (quad) when N lies in [REF_KHZ/216, REF_KHZ/170]. All divisions are integer divisions and all ranges are inclusive.
- R3: When N falls in none of the three ranges, the committed result is speed_mode 0, rate_unsupported 1 and ratio_ok 0.
- R4: In single mode, ratio_ok is 1 for master tick counts M per frame that match 256, 384, 512, 768 or 1024.
- R5: In double mode, ratio_ok is 1 for M matching 128, 192, 256, 384 or 512.
- R6: In quad mode, ratio_ok is 1 for M matching 128, 192 or 256, and 0 for every other multiple.
- R7: M matches a multiple K when |M-K| <= 1; an offset of 2 is rejected.
- R8: ratio_ok also requires 1024*N <= M*REF_KHZ <= 51200*N, i.e. an implied master clock of 1.024 to 51.2 MHz.
- R9: A result changes the outputs only at the lrck_in rising edge that ends the second of two consecutive periods with the same mode and ratio verdict. A single differing period changes nothing.
- R10: When the ref_tick count since the last lrck_in rise reaches 2*(REF_KHZ/4) without a rise in that cycle, the block sets clock_lost to 1 and sets speed_mode, ratio_ok and rate_unsupported to 0. The first rise after that only starts a new measurement. clock_lost clears at the next commit.
- R11: deemph_en equals deemph_req while speed_mode is 1 and is 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_in | input | 1 | Synchronised frame clock level |
| mclk_tick | input | 1 | One-cycle strobe per master clock cycle |
| ref_tick | input | 1 | One-cycle strobe per reference clock cycle |
| deemph_req | input | 1 | De-emphasis request |
| speed_mode | output | 2 | 0 none, 1 single, 2 double, 3 quad |
| ratio_ok | output | 1 | Master-to-frame ratio legal for the band |
| rate_unsupported | output | 1 | Committed frame rate lies outside every band |
| clock_lost | output | 1 | No frame edge within the timeout |
| deemph_en | output | 1 | Mode-gated de-emphasis enable |

## Verification
A frame edge and the loss timeout can land in the same cycle. This happens when a period lasts exactly the timeout count. The rule is that the edge wins and the long period is classified as unsupported rather than lost. The bench provokes this with a period equal to the timeout measured at one reference tick per cycle, and expects rate_unsupported 1 with clock_lost 0. It then repeats the run with a period one cycle longer and expects clock_lost 1 with rate_unsupported 0.

// File: rtl/rmd_pkg.sv
package rmd_pkg;

    typedef enum logic [1:0] {
        SPD_NONE   = 2'd0,
        SPD_SINGLE = 2'd1,
        SPD_DOUBLE = 2'd2,
        SPD_QUAD   = 2'd3
    } spd_mode_e;

    localparam int NUM_RATIOS = 7;

    // index 0..6 -> 128,192,256,384,512,768,1024
    function automatic int unsigned ratio_at(int idx);
        int unsigned base;
        base = 32'd128 << (idx / 2);
        return (idx % 2 == 1) ? (base * 3) / 2 : base;
    endfunction

    function automatic logic ratio_in_mode(spd_mode_e m, int idx);
        case (m)
            SPD_SINGLE: return idx >= 2;
            SPD_DOUBLE: return idx <= 4;
            SPD_QUAD:   return idx <= 2;
            default:    return 1'b0;
        endcase
    endfunction

    typedef struct packed {
        logic      lrck;
        logic      started;
        logic      pend_valid;
        spd_mode_e pend_mode;
        logic      pend_ok;
        spd_mode_e mode;
        logic      ratio_ok;
        logic      unsup;
        logic      lost;
    } det_state_t;

endpackage

// File: rtl/rmd_tick_counter.sv
module rmd_tick_counter #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)
            cnt_d = W'(tick);
        else if (tick && cnt_q != CNT_MAX)
            cnt_d = cnt_q + W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // the timeout (R10) relies on the count never wrapping
    assert_count_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/rmd_classify.sv
module rmd_classify
    import rmd_pkg::*;
#(
    parameter int unsigned REF_KHZ = 24576,
    parameter int unsigned RW      = 14,
    parameter int unsigned MW      = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ref_count,
    input  logic [MW-1:0] mclk_count,
    output spd_mode_e     mode,
    output logic          ratio_ok
);
    localparam int unsigned S_LO = REF_KHZ / 54;
    localparam int unsigned S_HI = REF_KHZ / 4;
    localparam int unsigned D_LO = REF_KHZ / 108;
    localparam int unsigned D_HI = REF_KHZ / 84;
    localparam int unsigned Q_LO = REF_KHZ / 216;
    localparam int unsigned Q_HI = REF_KHZ / 170;

    logic [31:0] rc32, mc32;
    logic        in_s, in_d, in_q;
    logic [63:0] mclk_scaled, lim_lo, lim_hi;
    logic        range_ok;
    logic [NUM_RATIOS-1:0] near, allow;

    assign rc32 = 32'(ref_count);
    assign mc32 = 32'(mclk_count);

    assign in_s = (rc32 >= S_LO) && (rc32 <= S_HI);
    assign in_d = (rc32 >= D_LO) && (rc32 <= D_HI);
    assign in_q = (rc32 >= Q_LO) && (rc32 <= Q_HI);

    always_comb begin
        if (in_s)      mode = SPD_SINGLE;
        else if (in_d) mode = SPD_DOUBLE;
        else if (in_q) mode = SPD_QUAD;
        else           mode = SPD_NONE;
    end

    // implied master frequency in kHz is mclk_count*REF_KHZ/ref_count
    assign mclk_scaled = 64'(mc32) * 64'(REF_KHZ);
    assign lim_lo      = 64'(rc32) * 64'd1024;
    assign lim_hi      = 64'(rc32) * 64'd51200;
    assign range_ok    = (mclk_scaled >= lim_lo) && (mclk_scaled <= lim_hi);

    for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_ratio
        localparam int unsigned RV = ratio_at(gi);
        assign near[gi]  = (mc32 + 32'd1 >= RV) && (mc32 <= RV + 32'd1);
        assign allow[gi] = ratio_in_mode(mode, gi);
    end

    assign ratio_ok = (mode != SPD_NONE) && (|(near & allow)) && range_ok;

    assert_single_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_s, in_d, in_q}));

    assert_ratio_has_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok |-> (mode != SPD_NONE && range_ok));

endmodule

// File: rtl/fs_mode_detector.sv
module fs_mode_detector
    import rmd_pkg::*;
#(
    parameter int unsigned REF_KHZ   = 24576,
    parameter int unsigned MAX_RATIO = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrck_in,
    input  logic       mclk_tick,
    input  logic       ref_tick,
    input  logic       deemph_req,
    output logic [1:0] speed_mode,
    output logic       ratio_ok,
    output logic       rate_unsupported,
    output logic       clock_lost,
    output logic       deemph_en
);
    localparam int unsigned SLOWEST = REF_KHZ / 4;
    localparam int unsigned TIMEOUT = 2 * SLOWEST;
    localparam int unsigned RW      = $clog2(TIMEOUT + 1);
    localparam int unsigned MW      = $clog2(2 * MAX_RATIO);

    det_state_t    s_d, s_q;
    logic          rise, tmo;
    logic [RW-1:0] ref_count;
    logic [MW-1:0] mclk_count;
    spd_mode_e     cand_mode;
    logic          cand_ok;

    assign rise = lrck_in & ~s_q.lrck;

    rmd_tick_counter #(.W(RW)) u_ref_cnt (
        .clk(clk), .rst_n(rst_n), .restart(rise), .tick(ref_tick), .count(ref_count)
    );

    rmd_tick_counter #(.W(MW)) u_mclk_cnt (
        .clk(clk), .rst_n(rst_n), .restart(rise), .tick(mclk_tick), .count(mclk_count)
    );

    rmd_classify #(.REF_KHZ(REF_KHZ), .RW(RW), .MW(MW)) u_cls (
        .clk(clk), .rst_n(rst_n), .ref_count(ref_count), .mclk_count(mclk_count),
        .mode(cand_mode), .ratio_ok(cand_ok)
    );

    // an edge in the timeout cycle wins over the timeout
    assign tmo = (32'(ref_count) >= TIMEOUT) && !rise;

    always_comb begin
        s_d      = s_q;
        s_d.lrck = lrck_in;
        if (rise) begin
            if (!s_q.started) begin
                s_d.started    = 1'b1;
                s_d.pend_valid = 1'b0;
            end else begin
                if (s_q.pend_valid && cand_mode == s_q.pend_mode && cand_ok == s_q.pend_ok) begin
                    s_d.mode     = cand_mode;
                    s_d.ratio_ok = cand_ok;
                    s_d.unsup    = (cand_mode == SPD_NONE);
                    s_d.lost     = 1'b0;
                end
                s_d.pend_valid = 1'b1;
                s_d.pend_mode  = cand_mode;
                s_d.pend_ok    = cand_ok;
            end
        end else if (tmo) begin
            s_d.lost       = 1'b1;
            s_d.mode       = SPD_NONE;
            s_d.ratio_ok   = 1'b0;
            s_d.unsup      = 1'b0;
            s_d.started    = 1'b0;
            s_d.pend_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{lrck: 1'b0, started: 1'b0, pend_valid: 1'b0, pend_mode: SPD_NONE,
                     pend_ok: 1'b0, mode: SPD_NONE, ratio_ok: 1'b0, unsup: 1'b0, lost: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign speed_mode       = s_q.mode;
    assign ratio_ok         = s_q.ratio_ok;
    assign rate_unsupported = s_q.unsup;
    assign clock_lost       = s_q.lost;
    assign deemph_en        = deemph_req && (s_q.mode == SPD_SINGLE);

    assert_unsup_no_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.unsup |-> (s_q.mode == SPD_NONE && !s_q.ratio_ok));

    assert_lost_no_ratio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lost |-> (!s_q.ratio_ok && s_q.mode == SPD_NONE));

    assert_mode_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode != $past(s_q.mode)) |-> $past(rise || tmo));

    assert_commit_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !s_q.pend_valid) |=> $stable(s_q.mode));

endmodule

// File: tb/sim_fs_mode_detector.sv
module sim_fs_mode_detector;

    localparam int REFK = 864;
    localparam int TMO  = 2 * (REFK / 4);
    localparam int MSAT = 2047;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck_in = 1'b0, mclk_tick = 1'b0, ref_tick = 1'b0, deemph_req = 1'b0;
    logic [1:0] speed_mode;
    logic       ratio_ok, rate_unsupported, clock_lost, deemph_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    fs_mode_detector #(.REF_KHZ(REFK), .MAX_RATIO(1024)) u0 (
        .clk(clk), .rst_n(rst_n), .lrck_in(lrck_in), .mclk_tick(mclk_tick),
        .ref_tick(ref_tick), .deemph_req(deemph_req), .speed_mode(speed_mode),
        .ratio_ok(ratio_ok), .rate_unsupported(rate_unsupported),
        .clock_lost(clock_lost), .deemph_en(deemph_en)
    );

    always #5 clk = ~clk;

    function automatic int gcd(int a, int b);
        while (b != 0) begin
            int t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int lcm(int a, int b);
        return (a / gcd(a, b)) * b;
    endfunction

    function automatic int exp_mode(int n);
        if (n >= REFK / 54 && n <= REFK / 4)   return 1;
        if (n >= REFK / 108 && n <= REFK / 84) return 2;
        if (n >= REFK / 216 && n <= REFK / 170) return 3;
        return 0;
    endfunction

    function automatic bit legal(int mode, int r);
        case (mode)
            1: return r == 256 || r == 384 || r == 512 || r == 768 || r == 1024;
            2: return r == 128 || r == 192 || r == 256 || r == 384 || r == 512;
            3: return r == 128 || r == 192 || r == 256;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit exp_ok(int mode, int m, int n);
        bit hit = 1'b0;
        longint sc;
        if (mode == 0) return 1'b0;
        for (int r = 64; r <= 1024; r += 64)
            if (legal(mode, r) && m >= r - 1 && m <= r + 1) hit = 1'b1;
        sc = longint'(m) * REFK;
        return hit && sc >= longint'(n) * 1024 && sc <= longint'(n) * 51200;
    endfunction

    task automatic run_cfg(int p, int m, int r, int periods, bit req);
        for (int k = 0; k < periods * p; k++) begin
            int ph = k % p;
            @(negedge clk);
            lrck_in    = (ph < (p + 1) / 2);
            mclk_tick  = (ph % m == 0);
            ref_tick   = (ph % r == 0);
            deemph_req = req;
        end
        #1;
    endtask

    task automatic compare(string tag, int em, bit eo, bit eu, bit el, bit ed);
        n_chk++;
        if (speed_mode !== 2'(em) || ratio_ok !== eo || rate_unsupported !== eu ||
            clock_lost !== el || deemph_en !== ed) begin
            n_bad++;
            $display("FAIL %s: got mode=%0d ok=%0b unsup=%0b lost=%0b deemph=%0b, expected mode=%0d ok=%0b unsup=%0b lost=%0b deemph=%0b",
                     tag, speed_mode, ratio_ok, rate_unsupported, clock_lost, deemph_en,
                     em, eo, eu, el, ed);
        end
    endtask

    // expected outputs for a steady configuration of period p, master every m, reference every r
    task automatic check_cfg(string tag, int p, int m, int r, bit req);
        int n  = (p + r - 1) / r;
        int mc = (p + m - 1) / m;
        int em;
        if (mc > MSAT) mc = MSAT;
        em = exp_mode(n);
        compare(tag, em, exp_ok(em, mc, n), em == 0, 1'b0, req && em == 1);
    endtask

    task automatic trial(string tag, int ratio, int n, bit req);
        int p = lcm(ratio, n);
        run_cfg(p, p / ratio, p / n, 3, req);
        check_cfg(tag, p, p / ratio, p / n, req);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
                $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        compare("R1 reset state", 0, 0, 0, 0, 0);

        // every legal multiple at band edges: R2 R4 R5 R6, and R8 at the top of single mode
        for (int i = 0; i < 7; i++) begin
            int r = (128 << (i / 2)) * ((i % 2) ? 3 : 2) / 2;
            if (legal(1, r)) trial("R4 R8 single lower edge", r, REFK / 54, 1'b1);
            if (legal(2, r)) begin
                trial("R5 double lower edge", r, REFK / 108, 1'b1);
                trial("R5 double upper edge", r, REFK / 84, 1'b0);
            end
            if (legal(3, r)) begin
                trial("R6 quad lower edge", r, REFK / 216, 1'b1);
                trial("R6 quad upper edge", r, REFK / 170, 1'b1);
            end
        end
        trial("R6 quad rejects 384", 384, REFK / 216, 1'b0);
        trial("R2 single upper edge", 384, REFK / 4, 1'b1);
        trial("R8 implied master at 1.024 MHz", 256, REFK / 4, 1'b0);

        // gaps and out-of-range counts: R3
        trial("R3 below quad", 128, 3, 1'b1);
        trial("R3 gap quad-double", 256, 7, 1'b0);
        trial("R3 gap double-single", 128, 11, 1'b1);
        run_cfg(3000, 1, 10, 3, 1'b1);
        check_cfg("R3 above single", 3000, 1, 10, 1'b1);

        // jitter tolerance: R7
        run_cfg(513, 1, 16, 3, 1'b0); check_cfg("R7 plus one", 513, 1, 16, 1'b0);
        run_cfg(511, 1, 16, 3, 1'b0); check_cfg("R7 minus one", 511, 1, 16, 1'b0);
        run_cfg(514, 1, 16, 3, 1'b0); check_cfg("R7 plus two", 514, 1, 16, 1'b0);
        run_cfg(510, 1, 16, 3, 1'b0); check_cfg("R7 minus two", 510, 1, 16, 1'b0);

        // single differing period leaves the result alone: R9
        run_cfg(512, 1, 16, 3, 1'b1);
        check_cfg("R9 baseline", 512, 1, 16, 1'b1);
        run_cfg(896, 7, 128, 1, 1'b1);
        run_cfg(512, 1, 16, 2, 1'b1);
        check_cfg("R9 glitch ignored", 512, 1, 16, 1'b1);

        // de-emphasis gating: R11
        trial("R11 double ignores request", 256, REFK / 96, 1'b1);
        trial("R11 single without request", 512, REFK / 48, 1'b0);

        // edge coinciding with timeout, then a true loss: R10
        run_cfg(TMO, 1, 1, 3, 1'b1);
        check_cfg("R10 edge wins at timeout", TMO, 1, 1, 1'b1);
        run_cfg(TMO + 1, 1, 1, 3, 1'b1);
        compare("R10 clock lost", 0, 0, 0, 1, 0);
        run_cfg(512, 1, 16, 3, 1'b1);
        check_cfg("R10 recovery clears loss", 512, 1, 16, 1'b1);

        // constrained random: R2 R4 R5 R6 R11
        for (int t = 0; t < 16; t++) begin
            int band, n, r, lo, hi, p;
            bit req;
            do begin
                band = 1 + int'($urandom % 3);
                lo = (band == 1) ? REFK / 54 : (band == 2) ? REFK / 108 : REFK / 216;
                hi = (band == 1) ? REFK / 4  : (band == 2) ? REFK / 84  : REFK / 170;
                n  = lo + int'($urandom % (hi - lo + 1));
                do r = (128 << ($urandom % 4)) * (($urandom % 2) ? 3 : 2) / 2;
                while (!legal(band, r));
                p = lcm(r, n);
            end while (p > 1500);
            req = 1'($urandom % 2);
            trial("R2 random band and ratio", r, n, req);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule